// File: doc/BRIEF.md
# Four-Channel Multi-Source Counter/Timer with Hold Capture

The block is a bank of four identical 16-bit counter/timer channels behind a small word-addressed register port. Each channel has three registers. The count register is the live counter. The target register is the compare value. The mode register holds the control fields and two sticky status flags. Channels 0 and 1 also have a hold register. It records the count at the moment an external peripheral event strobe is seen.

Each channel picks its tick from one of four sources:
- the bus clock, which runs at half the core clock;
- the bus clock divided by 16;
- the bus clock divided by 256;
- an external video pulse. Even channels follow the horizontal-blank input and odd channels follow the vertical-blank input.

When the count reaches the target, the compare flag is set. When the count wraps past its maximum, the overflow flag is set. A channel raises its interrupt output only when an enabled flag changes from clear to set. A flag that stays set does not raise a new interrupt.

Top module: `tmr_bank`

## Requirements
- R1: After reset, every count, target, mode and hold register reads 0 and every bit of `irq_o` is 0.
- R2: Register selection uses the word address. `addr_i[3:2]` selects the channel and `addr_i[1:0]` selects the register: 0 = count, 1 = mode, 2 = target, 3 = hold. Reads are combinational. A target write reads back unchanged. Mode bits 2..5 and 12..15 always read 0.
- R3: Mode bits [1:0] select the tick source. Bit 7 enables counting. With source 00, an enabled channel advances by one on every second core clock edge, at the 2nd, 4th, 6th edge after reset and so on.
- R4: Source 01 advances the count once every 32 core cycles, on the edge where a free-running core-cycle counter started at reset has its low 5 bits all ones. Source 10 advances once every 512 core cycles, on the edge where that counter's low 9 bits are all ones.
- R5: Source 11 counts rising edges of `hblank_i` on channels 0 and 2, and of `vblank_i` on channels 1 and 3. Each input passes through two synchronising flops and an edge detector. A rise that is sampled at edge k therefore advances the count at edge k+2, and a pulse that stays high counts only once.
- R6: The compare flag (mode bit 10) is set on the tick at which the new count equals the target. The match is equality only: the flag is raised once, not on every later cycle.
- R7: With zero-return (mode bit 6) set, the tick that follows a count equal to the target loads 0.
- R8: Otherwise a tick at 0xFFFF wraps the count to 0 and sets the overflow flag (mode bit 11).
- R9: Writing 1 to a flag bit of the mode register clears that flag. Writing 0 leaves it as it is. A flag that is set in the same cycle as it is cleared stays set.
- R10: `irq_o[c]` is high for exactly one cycle, in the cycle after the flag goes from 0 to 1, and only if that flag's enable is set. Bit 8 enables the compare interrupt and bit 9 enables the overflow interrupt. A flag that stays set never raises a second pulse.
- R11: When `periph_evt_i` is high at a clock edge, channels 0 and 1 copy the count they held before that edge into their hold registers. The hold registers of channels 2 and 3 always read 0.
- R12: A count write loads the written value at that edge, and no tick is applied in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Word address: channel in [3:2], register in [1:0] |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` (combinational) |
| hblank_i | input | 1 | Horizontal-blank pulse input (asynchronous) |
| vblank_i | input | 1 | Vertical-blank pulse input (asynchronous) |
| periph_evt_i | input | 1 | Peripheral event strobe; captures the count into the hold registers |
| irq_o | output | 4 | Per-channel interrupt pulse |

## Verification
Register writes, ticks and hold captures take effect at the edge where they are sampled. The bench therefore compares each read one nanosecond after the following falling edge, while the read port is still combinational. Interrupt pulses come out of one register stage, so they are compared with the reference model on every falling edge after the edge at which the flag changed. External blank pulses take three edges to reach the count. The reference model keeps its own three-stage pipeline for them, and the directed blank checks wait several idle cycles before sampling.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned MB_ZRET = 6;
  localparam int unsigned MB_EN   = 7;
  localparam int unsigned MB_CIE  = 8;
  localparam int unsigned MB_OIE  = 9;
  localparam int unsigned MB_CF   = 10;
  localparam int unsigned MB_OF   = 11;

  typedef enum logic [1:0] {
    SRC_BUS    = 2'd0,
    SRC_DIV_A  = 2'd1,
    SRC_DIV_B  = 2'd2,
    SRC_EXT    = 2'd3
  } clk_src_e;

  typedef enum logic [1:0] {
    REG_COUNT  = 2'd0,
    REG_MODE   = 2'd1,
    REG_TARGET = 2'd2,
    REG_HOLD   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic     oie;
    logic     cie;
    logic     en;
    logic     zret;
    clk_src_e src;
  } ctrl_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int unsigned DIV_A_LOG2 = 4,
  parameter int unsigned DIV_B_LOG2 = 8,
  localparam int unsigned PW = DIV_B_LOG2 + 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  output logic [2:0] tick_o
);
  logic [PW-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + PW'(1);
  end

  // [0] bus clock (core/2), [1] bus/2^A, [2] bus/2^B
  assign tick_o[0] = div_q[0];
  assign tick_o[1] = &div_q[DIV_A_LOG2:0];
  assign tick_o[2] = &div_q;
endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic pulse_o
);
  logic [2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[1:0], in_i};
  end

  assign pulse_o = sh_q[1] & ~sh_q[2];
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter bit          HAS_HOLD = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       src_tick_i,
  input  logic             wr_count_i,
  input  logic             wr_mode_i,
  input  logic             wr_target_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             hold_evt_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] target_o,
  output logic [CNT_W-1:0] mode_o,
  output logic [CNT_W-1:0] hold_o,
  output logic             irq_o
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] cnt_q, cnt_d, tgt_q;
  logic             cf_q, cf_d, of_q, of_d, irq_q;
  logic             tick, cmp_set, ovf_set;

  always_comb begin
    tick    = ctrl_q.en & src_tick_i[ctrl_q.src];
    cnt_d   = cnt_q;
    cmp_set = 1'b0;
    ovf_set = 1'b0;
    if (wr_count_i) begin
      cnt_d = wdata_i;
    end else if (tick) begin
      if (ctrl_q.zret && (cnt_q == tgt_q)) begin
        cnt_d = '0;
      end else if (&cnt_q) begin
        cnt_d   = '0;
        ovf_set = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
      cmp_set = (cnt_d == tgt_q);
    end
    // set wins over a simultaneous write-1 clear
    cf_d = cmp_set | (cf_q & ~(wr_mode_i & wdata_i[MB_CF]));
    of_d = ovf_set | (of_q & ~(wr_mode_i & wdata_i[MB_OF]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
      tgt_q  <= '0;
      cf_q   <= 1'b0;
      of_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      cf_q  <= cf_d;
      of_q  <= of_d;
      irq_q <= (~cf_q & cf_d & ctrl_q.cie) | (~of_q & of_d & ctrl_q.oie);
      if (wr_target_i) tgt_q <= wdata_i;
      if (wr_mode_i) begin
        ctrl_q.oie  <= wdata_i[MB_OIE];
        ctrl_q.cie  <= wdata_i[MB_CIE];
        ctrl_q.en   <= wdata_i[MB_EN];
        ctrl_q.zret <= wdata_i[MB_ZRET];
        ctrl_q.src  <= clk_src_e'(wdata_i[1:0]);
      end
    end
  end

  generate
    if (HAS_HOLD) begin : g_hold
      logic [CNT_W-1:0] hold_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         hold_q <= '0;
        else if (hold_evt_i) hold_q <= cnt_q;
      end
      assign hold_o = hold_q;
    end else begin : g_no_hold
      logic unused_evt;
      assign unused_evt = hold_evt_i;
      assign hold_o     = '0;
    end
  endgenerate

  always_comb begin
    mode_o          = '0;
    mode_o[1:0]     = ctrl_q.src;
    mode_o[MB_ZRET] = ctrl_q.zret;
    mode_o[MB_EN]   = ctrl_q.en;
    mode_o[MB_CIE]  = ctrl_q.cie;
    mode_o[MB_OIE]  = ctrl_q.oie;
    mode_o[MB_CF]   = cf_q;
    mode_o[MB_OF]   = of_q;
  end

  assign count_o  = cnt_q;
  assign target_o = tgt_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int unsigned N_CH       = 4,
  parameter int unsigned N_HOLD     = 2,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned DIV_A_LOG2 = 4,
  parameter int unsigned DIV_B_LOG2 = 8,
  localparam int unsigned CH_W      = $clog2(N_CH),
  localparam int unsigned ADDR_W    = CH_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  input  logic              hblank_i,
  input  logic              vblank_i,
  input  logic              periph_evt_i,
  output logic [N_CH-1:0]   irq_o
);
  logic [2:0]      pre_tick;
  logic            hb_pulse, vb_pulse;
  logic [CH_W-1:0] ch_sel;
  reg_sel_e        reg_sel;

  logic [CNT_W-1:0] cnt_a  [N_CH];
  logic [CNT_W-1:0] tgt_a  [N_CH];
  logic [CNT_W-1:0] mode_a [N_CH];
  logic [CNT_W-1:0] hold_a [N_CH];

  assign ch_sel  = addr_i[ADDR_W-1:2];
  assign reg_sel = reg_sel_e'(addr_i[1:0]);

  tmr_prescale #(
    .DIV_A_LOG2 (DIV_A_LOG2),
    .DIV_B_LOG2 (DIV_B_LOG2)
  ) i_prescale (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (pre_tick)
  );

  tmr_edge_sync i_hb_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .in_i    (hblank_i),
    .pulse_o (hb_pulse)
  );

  tmr_edge_sync i_vb_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .in_i    (vblank_i),
    .pulse_o (vb_pulse)
  );

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      logic ext_pulse, hit;
      // even channels follow hblank, odd channels vblank
      assign ext_pulse = (c % 2 == 0) ? hb_pulse : vb_pulse;
      assign hit       = we_i && (ch_sel == CH_W'(c));

      tmr_chan #(
        .CNT_W    (CNT_W),
        .HAS_HOLD (c < N_HOLD)
      ) i_chan (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .src_tick_i  ({ext_pulse, pre_tick}),
        .wr_count_i  (hit && reg_sel == REG_COUNT),
        .wr_mode_i   (hit && reg_sel == REG_MODE),
        .wr_target_i (hit && reg_sel == REG_TARGET),
        .wdata_i     (wdata_i),
        .hold_evt_i  (periph_evt_i),
        .count_o     (cnt_a[c]),
        .target_o    (tgt_a[c]),
        .mode_o      (mode_a[c]),
        .hold_o      (hold_a[c]),
        .irq_o       (irq_o[c])
      );
    end
  endgenerate

  always_comb begin
    unique case (reg_sel)
      REG_COUNT:  rdata_o = cnt_a[ch_sel];
      REG_MODE:   rdata_o = mode_a[ch_sel];
      REG_TARGET: rdata_o = tgt_a[ch_sel];
      default:    rdata_o = hold_a[ch_sel];
    endcase
  end
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
  parameter int unsigned N_CH   = 4,
  parameter int unsigned N_HOLD = 2,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [CNT_W-1:0]  wdata_i,
  input logic [CNT_W-1:0]  rdata_o,
  input logic [N_CH-1:0]   irq_o
);
  // R1
  rst_irq_chk: assert property (@(posedge clk_i)
    !rst_ni |-> irq_o == '0);

  // R10
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & $past(irq_o)) == '0);

  // R12
  cnt_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i[1:0] == 2'd0) ##1 (!we_i && $stable(addr_i))
    |-> rdata_o == $past(wdata_i));

  // R3
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(we_i) && $stable(addr_i) && addr_i[1:0] == 2'd0)
    |-> (rdata_o == $past(rdata_o) || rdata_o == CNT_W'($past(rdata_o) + 1'b1)
         || rdata_o == '0));

  // R11
  hold_none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[1:0] == 2'd3 && int'(addr_i[ADDR_W-1:2]) >= N_HOLD) |-> rdata_o == '0);
endmodule

bind tmr_bank tmr_bank_chk #(
  .N_CH   (N_CH),
  .N_HOLD (N_HOLD),
  .CNT_W  (CNT_W),
  .ADDR_W (ADDR_W)
) i_tmr_bank_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o)
);

// File: tb/test_tmr_bank.sv
module test_tmr_bank;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        hblank_i = 1'b0;
  logic        vblank_i = 1'b0;
  logic        periph_evt_i = 1'b0;
  logic [3:0]  irq_o;

  int nvec = 0;
  int nerr = 0;

  always #2.5 clk_i = ~clk_i;

  tmr_bank i_tmr_bank (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (we_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .rdata_o      (rdata_o),
    .hblank_i     (hblank_i),
    .vblank_i     (vblank_i),
    .periph_evt_i (periph_evt_i),
    .irq_o        (irq_o)
  );

  // reference model
  logic [15:0] m_cnt [4];
  logic [15:0] m_tgt [4];
  logic [15:0] m_hold [4];
  logic [1:0]  m_src [4];
  bit m_z [4], m_en [4], m_ci [4], m_oi [4], m_cf [4], m_of [4];
  logic [3:0] m_irq;
  logic [8:0] m_pc;
  logic [2:0] m_h, m_v;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < 4; c++) begin
        m_cnt[c] = '0; m_tgt[c] = '0; m_hold[c] = '0; m_src[c] = '0;
        m_z[c] = 0; m_en[c] = 0; m_ci[c] = 0; m_oi[c] = 0; m_cf[c] = 0; m_of[c] = 0;
      end
      m_irq = '0; m_pc = '0; m_h = '0; m_v = '0;
    end else begin
      bit bt, da, db, hp, vp;
      bt = m_pc[0]; da = &m_pc[4:0]; db = &m_pc;
      hp = m_h[1] & ~m_h[2]; vp = m_v[1] & ~m_v[2];
      for (int c = 0; c < 4; c++) begin
        logic [15:0] n;
        bit st, tk, cs, os, wc, wm, wt, cfn, ofn;
        case (m_src[c])
          2'd0: st = bt;
          2'd1: st = da;
          2'd2: st = db;
          default: st = (c % 2 == 0) ? hp : vp;
        endcase
        tk = m_en[c] && st;
        wc = we_i && addr_i == {c[1:0], 2'd0};
        wm = we_i && addr_i == {c[1:0], 2'd1};
        wt = we_i && addr_i == {c[1:0], 2'd2};
        n = m_cnt[c]; cs = 0; os = 0;
        if (wc) n = wdata_i;
        else if (tk) begin
          if (m_z[c] && m_cnt[c] == m_tgt[c]) n = '0;
          else if (m_cnt[c] == 16'hFFFF) begin n = '0; os = 1; end
          else n = m_cnt[c] + 16'd1;
          cs = (n == m_tgt[c]);
        end
        cfn = cs | (m_cf[c] & !(wm & wdata_i[10]));
        ofn = os | (m_of[c] & !(wm & wdata_i[11]));
        m_irq[c] = (!m_cf[c] && cfn && m_ci[c]) || (!m_of[c] && ofn && m_oi[c]);
        if (periph_evt_i && c < 2) m_hold[c] = m_cnt[c];
        m_cnt[c] = n; m_cf[c] = cfn; m_of[c] = ofn;
        if (wt) m_tgt[c] = wdata_i;
        if (wm) begin
          m_src[c] = wdata_i[1:0]; m_z[c] = wdata_i[6]; m_en[c] = wdata_i[7];
          m_ci[c] = wdata_i[8]; m_oi[c] = wdata_i[9];
        end
      end
      m_pc = m_pc + 9'd1;
      m_h = {m_h[1:0], hblank_i};
      m_v = {m_v[1:0], vblank_i};
    end
  end

  function automatic logic [15:0] mread(logic [3:0] a);
    int c = int'(a[3:2]);
    case (a[1:0])
      2'd0: return m_cnt[c];
      2'd1: return {4'b0, m_of[c], m_cf[c], m_oi[c], m_ci[c], m_en[c], m_z[c], 4'b0, m_src[c]};
      2'd2: return m_tgt[c];
      default: return m_hold[c];
    endcase
  endfunction

  function automatic string rtag(logic [1:0] r);
    case (r)
      2'd0: return "R3";
      2'd1: return "R9";
      2'd2: return "R2";
      default: return "R11";
    endcase
  endfunction

  task automatic cmp_rd(string tag);
    logic [15:0] exp;
    #1;
    exp = mread(addr_i);
    nvec++;
    if (rdata_o !== exp) begin
      nerr++;
      $display("FAIL %s addr=%0h actual=%04h expected=%04h", tag, addr_i, rdata_o, exp);
    end
  endtask

  task automatic chk(logic [3:0] a, string tag);
    addr_i = a;
    cmp_rd(tag);
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  // R10: interrupt outputs compared every cycle
  always @(negedge clk_i) begin
    if (rst_ni) begin
      nvec++;
      if (irq_o !== m_irq) begin
        nerr++;
        $display("FAIL R10 irq actual=%b expected=%b", irq_o, m_irq);
      end
    end
  end

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  endtask

  initial begin
    #500000;
    nerr++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd7));
    idle(3);
    rst_ni = 1'b1;
    // R1
    for (int a = 0; a < 16; a++) chk(4'(a), "R1");
    // R2
    for (int c = 0; c < 4; c++) wr({2'(c), 2'd2}, 16'h1234 ^ 16'(c * 16'h0F0F));
    for (int c = 0; c < 4; c++) chk({2'(c), 2'd2}, "R2");
    wr(4'hD, 16'hFFFF);
    chk(4'hD, "R2");
    wr(4'hD, 16'h0000);
    // R12, R3
    wr(4'h1, 16'h0080);
    wr(4'h0, 16'h0100);
    chk(4'h0, "R12");
    idle(10);
    chk(4'h0, "R3");
    // R4
    wr(4'h5, 16'h0081);
    wr(4'h9, 16'h0082);
    idle(1100);
    chk(4'h4, "R4");
    chk(4'h8, "R4");
    // R5
    wr(4'h1, 16'h0083); wr(4'h0, 16'h0000);
    wr(4'h5, 16'h0083); wr(4'h4, 16'h0000);
    repeat (3) begin hblank_i = 1'b1; idle(2); hblank_i = 1'b0; idle(3); end
    repeat (5) begin vblank_i = 1'b1; idle(1); vblank_i = 1'b0; idle(2); end
    hblank_i = 1'b1; idle(10); hblank_i = 1'b0;
    idle(4);
    chk(4'h0, "R5");
    chk(4'h4, "R5");
    // R6, R10
    wr(4'hA, 16'd30); wr(4'h8, 16'd0); wr(4'h9, 16'h0180);
    idle(70);
    chk(4'h9, "R6");
    chk(4'h8, "R6");
    // R9
    wr(4'h9, 16'h0180);
    chk(4'h9, "R9");
    wr(4'h9, 16'h0580);
    chk(4'h9, "R9");
    // R7
    wr(4'hE, 16'd5); wr(4'hC, 16'd0); wr(4'hD, 16'h03C0);
    idle(7);
    chk(4'hC, "R7");
    idle(13);
    chk(4'hC, "R7");
    chk(4'hD, "R7");
    // R8
    wr(4'hD, 16'h0280); wr(4'hC, 16'hFFF8);
    idle(30);
    chk(4'hD, "R8");
    chk(4'hC, "R8");
    // R11
    wr(4'h1, 16'h0080);
    idle(5);
    @(negedge clk_i); periph_evt_i = 1'b1;
    @(negedge clk_i); periph_evt_i = 1'b0;
    for (int c = 0; c < 4; c++) chk({2'(c), 2'd3}, "R11");
    // random phase
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk_i);
      we_i = ($urandom % 8) == 0;
      addr_i = 4'($urandom);
      wdata_i = 16'($urandom);
      if (addr_i[1:0] == 2'd1) wdata_i[7] = 1'b1;
      if (addr_i[1:0] == 2'd0 && ($urandom % 2) == 1) wdata_i = wdata_i | 16'hFFE0;
      if (addr_i[1:0] == 2'd2 && ($urandom % 2) == 1) wdata_i = wdata_i & 16'h001F;
      hblank_i = ($urandom % 4) == 0;
      vblank_i = ($urandom % 3) == 0;
      periph_evt_i = ($urandom % 16) == 0;
      cmp_rd(rtag(addr_i[1:0]));
    end
    @(negedge clk_i);
    we_i = 1'b0; periph_evt_i = 1'b0;
    idle(2);
    summary();
  end
endmodule